// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block recovers packets from the differential D+/D- pair of a low-speed USB link. It runs from a clock at ten times the bit rate and needs no clock recovery beyond lining up with the sync field. Both lines first pass through two-flop synchronisers. The block then waits for the bus to reach idle and hunts for the sync field. It locks its bit phase to the J-to-K edge that comes before the closing double-K of sync.

After it locks, the block samples one point per bit time near the bit centre. It decodes NRZI, drops stuffed bits and assembles bytes least significant bit first. Each completed byte is written to an external byte buffer through a single-cycle write strobe with an address and data. A single-ended zero ends the packet. A packet-done strobe carrying the byte count is raised only when the bus then returns to J. If a packet holds more bytes than the buffer can take, the block raises an overflow strobe and abandons the packet. A sync attempt that stalls raises a sync-error strobe.

Top module: `usb_ls_rx`

## Requirements
- R1: The line states are J (D+ 0, D- 1, bus idle), K (D+ 1, D- 0) and SE0 (both 0). After reset and after every packet, the block waits until D- is high before it looks for sync. An idle J bus produces no write, done, overflow or sync-error strobe.
- R2: The block aligns to each J-to-K edge. It then takes one sample 15 clocks after that edge. If the sample is K, the sync field is complete. Otherwise the block waits for the next K edge. A sync field with extra leading K/J pairs therefore still locks on its final double-K.
- R3: Each line passes through two flip-flops before it is used. After lock, the block takes exactly one sample every OVERSAMPLE (10) clocks.
- R4: A sample at the same level (D-) as the previous sample decodes to data 1. A change of level decodes to data 0. The closing K of sync serves as the first previous level.
- R5: After STUFF_RUN (6) consecutive decoded 1 bits, the next sample is a stuffed bit and is discarded. The closing sync bit counts as the first 1 of a run.
- R6: Bytes are assembled least significant bit first. Each byte is written with a one-cycle write strobe at consecutive addresses, starting at 0 in every packet.
- R7: SE0 sampled at bit position 0 of a byte does not end the packet; it is decoded as a K level. SE0 at any other bit position ends the packet, and the partial byte is discarded.
- R8: Once the packet has ended on SE0, the first non-SE0 sample decides the outcome. If it is J, a done strobe is raised with the number of complete bytes. If it is K, or if a third SE0 sample arrives, the packet is dropped and no done strobe is raised.
- R9: A packet may hold up to BUF_DEPTH (11) bytes and completes normally at that size. When byte BUF_DEPTH+1 completes, it is not written. The overflow strobe is raised, no done strobe follows, and the block returns to waiting for idle.
- R10: If the double-K check fails and no K then arrives within OVERSAMPLE clocks, the block raises a one-cycle sync-error strobe and returns to waiting for idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, ten times the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| usb_dp | input | 1 | D+ line, asynchronous |
| usb_dm | input | 1 | D- line, asynchronous |
| buf_we | output | 1 | Byte buffer write strobe |
| buf_addr | output | $clog2(BUF_DEPTH) | Byte buffer write address |
| buf_wdata | output | 8 | Byte buffer write data |
| pkt_done | output | 1 | Valid end-of-packet strobe |
| pkt_len | output | $clog2(BUF_DEPTH+1) | Complete bytes in the packet, valid with pkt_done |
| pkt_overflow | output | 1 | Buffer overflow strobe; the packet is abandoned |
| sync_error | output | 1 | Sync hunt timeout strobe |

## Verification
Packets are sent with several kinds of content. Mixed bit patterns check NRZI decoding and byte order. Long runs of ones force stuffed bits inside bytes and across byte boundaries, which separates correct unstuffing from a shifted or over-long byte. Endings are varied: a normal end-of-packet, a dribble bit, SE0 partway through a byte, a one-bit SE0 glitch on bit 0, and an SE0 followed by K. Together these show which SE0 positions end a packet and which endings count as valid. A lengthened sync field, an aborted sync, and packets of exactly BUF_DEPTH and BUF_DEPTH+1 bytes cover alignment, the timeout and the buffer limit.

// File: rtl/usbrx_pkg.sv
// Shared types for the low-speed receiver.
package usbrx_pkg;
    // Phases of the sync hunt and receive sequencer.
    typedef enum logic [2:0] {
        AL_WAIT_IDLE,
        AL_WAIT_EDGE,
        AL_CHECK_KK,
        AL_REEDGE,
        AL_RECEIVE
    } align_state_t;
endpackage

// File: rtl/usbrx_insync.sv
// Multi-stage synchroniser for a bundle of asynchronous lines.
// Assumes every line is independent and STAGES is at least 2.
module usbrx_insync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain;
        // Shift the raw line through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d[g]};
        end
        assign q[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/usbrx_align.sv
// Sync hunt and bit-phase sequencer. Waits for idle, locks on each J-to-K
// edge, and confirms sync when the next bit centre is still K. Once locked,
// it emits one registered line sample per bit time until the decoder stops it.
// Assumes synchronised inputs and a clock of OVERSAMPLE times the bit rate.
module usbrx_align
    import usbrx_pkg::*;
#(
    parameter int OVERSAMPLE = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_dp,
    input  logic line_dm,
    input  logic stop,
    output logic smp_stb,
    output logic smp_dp,
    output logic smp_dm,
    output logic start,
    output logic sync_err
);
    localparam int KK_AT   = OVERSAMPLE + OVERSAMPLE / 2 - 1;
    localparam int BIT_AT  = OVERSAMPLE - 1;
    localparam int TOUT_AT = OVERSAMPLE - 1;
    localparam int CW      = $clog2(KK_AT + 1);

    align_state_t   st;
    logic [CW-1:0]  cnt;
    logic           line_k;

    assign line_k = line_dp & ~line_dm;

    // Sequence the hunt, the double-K check and per-bit sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= AL_WAIT_IDLE;
            cnt      <= '0;
            smp_stb  <= 1'b0;
            smp_dp   <= 1'b0;
            smp_dm   <= 1'b0;
            start    <= 1'b0;
            sync_err <= 1'b0;
        end else begin
            smp_stb  <= 1'b0;
            start    <= 1'b0;
            sync_err <= 1'b0;
            case (st)
                AL_WAIT_IDLE: if (line_dm) st <= AL_WAIT_EDGE;
                AL_WAIT_EDGE: if (line_k) begin
                    st  <= AL_CHECK_KK;
                    cnt <= '0;
                end
                AL_CHECK_KK: begin
                    if (cnt == CW'(KK_AT)) begin
                        cnt <= '0;
                        if (line_k) begin
                            st    <= AL_RECEIVE;
                            start <= 1'b1;
                        end else begin
                            st <= AL_REEDGE;
                        end
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                AL_REEDGE: begin
                    if (line_k) begin
                        st  <= AL_CHECK_KK;
                        cnt <= '0;
                    end else if (cnt == CW'(TOUT_AT)) begin
                        st       <= AL_WAIT_IDLE;
                        sync_err <= 1'b1;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                AL_RECEIVE: begin
                    if (stop) begin
                        st <= AL_WAIT_IDLE;
                    end else if (cnt == CW'(BIT_AT)) begin
                        cnt     <= '0;
                        smp_stb <= 1'b1;
                        smp_dp  <= line_dp;
                        smp_dm  <= line_dm;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: st <= AL_WAIT_IDLE;
            endcase
        end
    end

    // Samples are at least a bit time apart, never back to back.
    assert_stb_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> !smp_stb);
endmodule

// File: rtl/usbrx_decode.sv
// Bit decoder: NRZI decode, stuffed-bit removal, LSB-first byte assembly,
// buffer writes, end-of-packet qualification and overflow detection.
// Assumes one sample strobe per bit time from the sequencer and a start
// pulse on the closing double-K of sync.
module usbrx_decode #(
    parameter int BUF_DEPTH = 11,
    parameter int STUFF_RUN = 6,
    localparam int AW = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1,
    localparam int LW = $clog2(BUF_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          smp_stb,
    input  logic          smp_dp,
    input  logic          smp_dm,
    output logic          stop,
    output logic          busy,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          done,
    output logic [LW-1:0] done_len,
    output logic          ovf
);
    localparam int RW = $clog2(STUFF_RUN + 1);

    logic          active;
    logic          in_eop;
    logic [1:0]    eop_se0;
    logic          prev;
    logic [RW-1:0] ones;
    logic [2:0]    bitpos;
    logic [6:0]    shreg;
    logic [LW-1:0] count;
    logic          se0, is_j, bit_val;

    assign se0     = ~smp_dp & ~smp_dm;
    assign is_j    = ~smp_dp & smp_dm;
    assign bit_val = (smp_dm == prev);
    assign busy    = active;

    // Decode each sample and produce writes and end-of-packet outcomes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            in_eop   <= 1'b0;
            eop_se0  <= '0;
            prev     <= 1'b0;
            ones     <= '0;
            bitpos   <= '0;
            shreg    <= '0;
            count    <= '0;
            stop     <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            done     <= 1'b0;
            done_len <= '0;
            ovf      <= 1'b0;
        end else begin
            stop  <= 1'b0;
            wr_en <= 1'b0;
            done  <= 1'b0;
            ovf   <= 1'b0;
            if (start) begin
                active  <= 1'b1;
                in_eop  <= 1'b0;
                eop_se0 <= '0;
                prev    <= 1'b0;
                ones    <= RW'(1);
                bitpos  <= '0;
                count   <= '0;
            end else if (active && smp_stb) begin
                if (in_eop) begin
                    if (se0) begin
                        if (eop_se0 == 2'd2) begin
                            active <= 1'b0;
                            stop   <= 1'b1;
                        end else begin
                            eop_se0 <= eop_se0 + 2'd1;
                        end
                    end else begin
                        active <= 1'b0;
                        stop   <= 1'b1;
                        if (is_j) begin
                            done     <= 1'b1;
                            done_len <= count;
                        end
                    end
                end else if (se0 && bitpos != 3'd0) begin
                    in_eop  <= 1'b1;
                    eop_se0 <= 2'd1;
                end else begin
                    prev <= smp_dm;
                    if (ones == RW'(STUFF_RUN)) begin
                        ones <= '0;
                    end else begin
                        ones   <= bit_val ? ones + RW'(1) : '0;
                        shreg  <= {bit_val, shreg[6:1]};
                        bitpos <= bitpos + 3'd1;
                        if (bitpos == 3'd7) begin
                            if (count == LW'(BUF_DEPTH)) begin
                                ovf    <= 1'b1;
                                active <= 1'b0;
                                stop   <= 1'b1;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_addr <= AW'(count);
                                wr_data <= {bit_val, shreg};
                                count   <= count + LW'(1);
                            end
                        end
                    end
                end
            end
        end
    end

    // A byte write, a done and an overflow never share a cycle.
    assert_single_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, done, ovf}));

    // After a packet is finished or abandoned, no write follows at once.
    assert_quiet_after_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || ovf) |=> !wr_en);
endmodule

// File: rtl/usb_ls_rx.sv
// Low-speed USB packet receiver top. Chains input synchronisers, the sync
// and bit-phase sequencer, and the bit decoder.
// Assumes clk runs at OVERSAMPLE times the line bit rate.
module usb_ls_rx #(
    parameter int OVERSAMPLE = 10,
    parameter int SYNC_FLOPS = 2,
    parameter int BUF_DEPTH  = 11,
    parameter int STUFF_RUN  = 6,
    localparam int AW = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1,
    localparam int LW = $clog2(BUF_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          usb_dp,
    input  logic          usb_dm,
    output logic          buf_we,
    output logic [AW-1:0] buf_addr,
    output logic [7:0]    buf_wdata,
    output logic          pkt_done,
    output logic [LW-1:0] pkt_len,
    output logic          pkt_overflow,
    output logic          sync_error
);
    logic s_dp, s_dm;
    logic smp_stb, smp_dp, smp_dm, start, stop, dec_busy;

    usbrx_insync #(.WIDTH(2), .STAGES(SYNC_FLOPS)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({usb_dp, usb_dm}), .q({s_dp, s_dm})
    );

    usbrx_align #(.OVERSAMPLE(OVERSAMPLE)) u_align (
        .clk(clk), .rst_n(rst_n),
        .line_dp(s_dp), .line_dm(s_dm), .stop(stop),
        .smp_stb(smp_stb), .smp_dp(smp_dp), .smp_dm(smp_dm),
        .start(start), .sync_err(sync_error)
    );

    usbrx_decode #(.BUF_DEPTH(BUF_DEPTH), .STUFF_RUN(STUFF_RUN)) u_dec (
        .clk(clk), .rst_n(rst_n),
        .start(start), .smp_stb(smp_stb), .smp_dp(smp_dp), .smp_dm(smp_dm),
        .stop(stop), .busy(dec_busy),
        .wr_en(buf_we), .wr_addr(buf_addr), .wr_data(buf_wdata),
        .done(pkt_done), .done_len(pkt_len), .ovf(pkt_overflow)
    );

    // A sync lock only happens while the decoder is idle.
    assert_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !dec_busy);

    // A sync timeout never interrupts a packet in progress.
    assert_syncerr_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sync_error |-> !dec_busy);
endmodule

// File: tb/usb_ls_rx_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the line driver pushes expected bytes and lengths into
// queues, and a monitor pops and compares them as the receiver produces them.
module usb_ls_rx_test;
    localparam int DEPTH = 11;
    localparam int OVS   = 10;

    typedef struct { int addr; int data; } wr_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       usb_dp = 1'b0;
    logic       usb_dm = 1'b1;
    logic       buf_we;
    logic [3:0] buf_addr;
    logic [7:0] buf_wdata;
    logic       pkt_done;
    logic [3:0] pkt_len;
    logic       pkt_overflow;
    logic       sync_error;

    usb_ls_rx uut (
        .clk(clk), .rst_n(rst_n), .usb_dp(usb_dp), .usb_dm(usb_dm),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .pkt_done(pkt_done), .pkt_len(pkt_len),
        .pkt_overflow(pkt_overflow), .sync_error(sync_error)
    );

    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    wr_item_t exp_wr[$];
    int       exp_len[$];
    int ovf_seen = 0, serr_seen = 0, done_seen = 0, we_seen = 0;
    logic lvl = 1'b1;
    int   ones = 0;
    logic [7:0] pkt [0:15];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: compare every write and done against the scoreboard queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (buf_we) begin
                we_seen++;
                if (exp_wr.size() == 0) begin
                    check(1'b0, "R6", "unexpected write", int'(buf_wdata), -1);
                end else begin
                    wr_item_t it;
                    it = exp_wr.pop_front();
                    check(int'(buf_wdata) == it.data, "R4 R5 R6", "byte data",
                          int'(buf_wdata), it.data);
                    check(int'(buf_addr) == it.addr, "R6", "byte address",
                          int'(buf_addr), it.addr);
                end
            end
            if (pkt_done) begin
                done_seen++;
                if (exp_len.size() == 0) begin
                    check(1'b0, "R8", "unexpected done", int'(pkt_len), -1);
                end else begin
                    int e;
                    e = exp_len.pop_front();
                    check(int'(pkt_len) == e, "R8", "packet length", int'(pkt_len), e);
                end
            end
            if (pkt_overflow) ovf_seen++;
            if (sync_error)   serr_seen++;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(1'b0, "R3", "watchdog expired", cyc, 150000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic drive(input logic dp, input logic dm);
        usb_dp = dp;
        usb_dm = dm;
        repeat (OVS) @(negedge clk);
    endtask

    // Emit one NRZI bit; optionally show a K level as SE0.
    task automatic emit_bit(input logic b, input logic se0_if_k);
        if (!b) lvl = ~lvl;
        if (se0_if_k && !lvl) drive(1'b0, 1'b0);
        else                  drive(~lvl, lvl);
    endtask

    task automatic emit_data(input logic b, input logic se0_if_k);
        emit_bit(b, se0_if_k);
        if (b) ones++;
        else   ones = 0;
        if (ones == 6) begin
            emit_bit(1'b0, 1'b0);
            ones = 0;
        end
    endtask

    task automatic idle(input int bits);
        lvl = 1'b1;
        repeat (bits) drive(1'b0, 1'b1);
    endtask

    // tail: 0 normal, 1 dribble, 2 SE0 then K, 3 SE0 mid-byte
    task automatic send_packet(input int n, input int tail, input bit long_sync,
                               input int glitch_idx);
        logic [7:0] v;
        lvl = 1'b1;
        if (long_sync) begin
            emit_bit(1'b0, 1'b0);
            emit_bit(1'b0, 1'b0);
        end
        for (int i = 0; i < 8; i++) emit_bit(i == 7, 1'b0);
        ones = 1;
        for (int k = 0; k < n; k++) begin
            v = pkt[k];
            if (k == glitch_idx) v[0] = lvl ? 1'b0 : 1'b1;
            if (k < DEPTH) exp_wr.push_back('{addr: k, data: int'(v)});
            for (int i = 0; i < 8; i++) emit_data(v[i], (k == glitch_idx) && (i == 0));
        end
        if (tail == 1) emit_bit(1'b1, 1'b0);
        if (tail == 3) begin
            emit_data(1'b1, 1'b0);
            emit_data(1'b0, 1'b0);
            emit_data(1'b1, 1'b0);
        end
        drive(1'b0, 1'b0);
        drive(1'b0, 1'b0);
        if (tail == 2) drive(1'b1, 1'b0);
        if (tail != 2 && n <= DEPTH) exp_len.push_back(n);
        idle(20);
    endtask

    task automatic expect_drained(input string req, input int dones_before, input int exp_dones);
        check(exp_wr.size() == 0, req, "bytes left unwritten", exp_wr.size(), 0);
        check(exp_len.size() == 0, req, "done strobes missing", exp_len.size(), 0);
        check(done_seen - dones_before == exp_dones, req, "done count",
              done_seen - dones_before, exp_dones);
    endtask

    initial begin
        int d0;
        repeat (5) @(negedge clk);
        check(buf_we == 1'b0 && pkt_done == 1'b0, "R6", "reset outputs idle",
              int'({buf_we, pkt_done}), 0);
        check(pkt_overflow == 1'b0 && sync_error == 1'b0, "R9", "reset error strobes",
              int'({pkt_overflow, sync_error}), 0);
        rst_n = 1'b1;
        idle(30);
        check(we_seen == 0 && done_seen == 0 && serr_seen == 0 && ovf_seen == 0,
              "R1", "idle bus quiet", we_seen + done_seen + serr_seen + ovf_seen, 0);

        // R3 R4: mixed content, normal end of packet
        pkt[0] = 8'h2D; pkt[1] = 8'h00; pkt[2] = 8'h10;
        d0 = done_seen; send_packet(3, 0, 0, -1); expect_drained("R3 R4", d0, 1);

        // R5: long runs of ones force stuffing inside and across bytes
        pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'h7E; pkt[3] = 8'h3F;
        d0 = done_seen; send_packet(4, 0, 0, -1); expect_drained("R5", d0, 1);

        // R7: dribble bit before SE0
        pkt[0] = 8'hA5; pkt[1] = 8'h5A; pkt[2] = 8'hC3;
        d0 = done_seen; send_packet(3, 1, 0, -1); expect_drained("R7", d0, 1);

        // R7: one-bit SE0 on bit 0 of byte 1 is read as K, packet continues
        pkt[0] = 8'h11; pkt[1] = 8'h22; pkt[2] = 8'h33;
        d0 = done_seen; send_packet(3, 0, 0, 1); expect_drained("R7", d0, 1);

        // R7: SE0 mid-byte drops the partial byte
        pkt[0] = 8'h44; pkt[1] = 8'h55;
        d0 = done_seen; send_packet(2, 3, 0, -1); expect_drained("R7", d0, 1);

        // R8: SE0 followed by K gives no done
        pkt[0] = 8'h66;
        d0 = done_seen; send_packet(1, 2, 0, -1); expect_drained("R8", d0, 0);

        // R9: one byte beyond the buffer
        for (int k = 0; k < 12; k++) pkt[k] = 8'(8'h30 + k);
        d0 = done_seen; send_packet(12, 0, 0, -1); expect_drained("R9", d0, 0);
        check(ovf_seen == 1, "R9", "overflow strobes", ovf_seen, 1);

        // R9: exactly full buffer completes normally
        for (int k = 0; k < 11; k++) pkt[k] = 8'(8'hC0 ^ k);
        d0 = done_seen; send_packet(11, 0, 0, -1); expect_drained("R9", d0, 1);
        check(ovf_seen == 1, "R9", "no overflow at full size", ovf_seen, 1);

        // R10: K then J then idle stalls the hunt
        drive(1'b1, 1'b0);
        drive(1'b0, 1'b1);
        idle(10);
        check(serr_seen == 1, "R10", "sync error strobes", serr_seen, 1);

        // R2: lengthened sync still locks on the double-K
        pkt[0] = 8'h99; pkt[1] = 8'h01;
        d0 = done_seen; send_packet(2, 0, 1, -1); expect_drained("R2", d0, 1);
        check(serr_seen == 1, "R2", "no sync error on valid sync", serr_seen, 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule